// File: doc/BRIEF.md
# Synchronous Transmitter with CRC Append

This block is a byte-oriented synchronous serial transmitter. The host writes characters into a single-entry holding buffer. Each character moves into a shift register and leaves on `txd` at one bit per clock, most-significant bit first. A CRC-16 generator (polynomial 0x1021) accumulates over the data characters that were marked for checking. When the transmitter runs dry, an end-of-message latch decides what follows. If the latch is clear, the accumulated CRC is appended automatically. If the latch is set, the line carries idle sync characters.

The latch is set only by the hardware, at the moment a CRC starts going out. That event also raises a one-cycle status interrupt. The host clears the latch with a command strobe, or the latch can clear itself on the first data write. Turning the transmitter off never truncates a character. During a CRC the remaining bit times are still sent, but they come from the sync register. Modem control is handled by two signals: an inverted request-to-send output and a clear-to-send input, which can optionally gate the transmitter.

Register map (`wr_addr`):
- 0: transmit data.
- 1: control. Bit 0 is transmit enable, bit 1 the RTS bit, bit 2 the CRC-enable bit, bits 4:3 the length code, bit 5 CTS auto-enable, bit 6 EOM auto-clear, bit 7 the CRC preset (1 means all ones).
- 2: sync character.
- 3: mode. Bit 0 selects an inverted CRC.

Top module: `sync_tx_crc`

## Requirements
- R1: After reset `txd` is 1, `rts_n` is 1, `buf_empty` is 1, `eom` is 1 and `ext_irq` is 0.
- R2: A data character is the low L bits of the byte written to address 0, with L = 5 + control[4:3]. It is sent MSB first. Characters follow each other without gaps when the buffer is refilled before the current character ends.
- R3: When the buffer is empty and `eom` is 1, the 8-bit sync character (address 2) is sent MSB first, repeatedly.
- R4: An underrun happens when the buffer is empty at a character boundary. If `eom` is 0 at that point, a 16-bit CRC is sent MSB first. The CRC uses x^16+x^12+x^5+1 and covers the bits of every data character whose control[2] was 1 when it was loaded. It starts from the value chosen by control[7], loaded by `cmd_reset_crc`, and is inverted when mode[0] is 1.
- R5: `eom` becomes 1 when a CRC starts, and `ext_irq` pulses for exactly one cycle at the same time. Once set, `eom` stays 1 until it is cleared, and `cmd_reset_eom` clears it.
- R6: With control[6] set, a write to address 0 also clears `eom`.
- R7: If transmit enable is cleared mid-character, that character completes and then `txd` holds 1. A byte waiting in the buffer stays there (`buf_empty` 0), and no CRC is started.
- R8: If enable is cleared during a CRC, all 16 bit times are still sent. CRC bit k (k = 0 is the first) comes from the CRC until the clear takes effect, and from sync[7 - (k mod 8)] afterwards. After the 16th bit the line goes to 1.
- R9: `rts_n` is the inverse of control[1].
- R10: `cts_status` equals the inverse of `cts_n`, delayed by one clock. With control[5] clear, `cts_n` does not affect transmission. With control[5] set, `cts_n` high holds the transmitter off and `cts_n` low lets it run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host register address |
| wr_data | input | 8 | Host register write data |
| cmd_reset_eom | input | 1 | Clear the end-of-message latch |
| cmd_reset_crc | input | 1 | Load the CRC with its preset value |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial data out |
| rts_n | output | 1 | Request-to-send, active low |
| cts_status | output | 1 | Registered clear-to-send level |
| buf_empty | output | 1 | Transmit buffer can accept a byte |
| eom | output | 1 | End-of-message latch |
| ext_irq | output | 1 | One-cycle status interrupt on `eom` set |

## Verification
The assertions assume the host issues `cmd_reset_crc` only while no data character is shifting. They also assume no data byte is written on the same edge as an underrun, and that the control register does not change the character length during a character. The bench keeps within these limits in three ways:
- Every setup write is made while the transmitter is off.
- A data byte is written only on the cycle after `buf_empty` is seen high, which lies at least five bit times before the next boundary.
- The only control write made mid-stream clears transmit enable, at a chosen bit index.

// File: rtl/stx_pkg.sv
package stx_pkg;
    // Serializer phase: off, idle sync fill, data character, CRC trailer.
    typedef enum logic [1:0] {ST_OFF, ST_SYNC, ST_DATA, ST_CRC} tx_state_e;

    // Control register layout, MSB first.
    typedef struct packed {
        logic       preset_ones;
        logic       auto_eom;
        logic       auto_cts;
        logic [1:0] len_code;
        logic       crc_en;
        logic       rts;
        logic       tx_en;
    } ctrl_t;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_SYNC = 2'd2;
    localparam logic [1:0] A_MODE = 2'd3;
endpackage

// File: rtl/stx_regs.sv
// Host-visible registers and the single-entry transmit buffer.
// Assumes DATA_W >= 8 so a control byte fits one write.
module stx_regs
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              cts_n,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] sync_q,
    output logic              crc_inv_q,
    output logic [DATA_W-1:0] buf_q,
    output logic              buf_full,
    output logic              cts_seen,
    output logic              data_wr
);
    assign data_wr = wr_en && (wr_addr == A_DATA);

    // Configuration registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            sync_q    <= '0;
            crc_inv_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) ctrl_q    <= ctrl_t'(wr_data[7:0]);
            if (wr_addr == A_SYNC) sync_q    <= wr_data;
            if (wr_addr == A_MODE) crc_inv_q <= wr_data[0];
        end
    end

    // Holding buffer: a write fills it, a load into the shifter empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_q    <= '0;
        end else if (data_wr) begin
            buf_full <= 1'b1;
            buf_q    <= wr_data;
        end else if (take) begin
            buf_full <= 1'b0;
        end
    end

    // Registered clear-to-send level for status.
    always_ff @(posedge clk) begin
        if (!rst_n) cts_seen <= 1'b0;
        else        cts_seen <= ~cts_n;
    end
endmodule

// File: rtl/stx_crc.sv
// Bit-serial CRC generator, MSB-first, with a combinational look-ahead
// value so a trailer can be loaded on the same edge as the last data bit.
module stx_crc #(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             preset_ones,
    input  logic             step,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic             fb;

    // Next remainder: preset command, one division step, or hold.
    always_comb begin
        fb = crc_q[CRC_W-1] ^ bit_in;
        if (clr)       crc_next = preset_ones ? '1 : '0;
        else if (step) crc_next = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        else           crc_next = crc_q;
    end

    // Remainder register.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_next;
    end
endmodule

// File: rtl/stx_shifter.sv
// Character sequencer and output shifter. Decides at each character
// boundary between off, data, CRC trailer and sync fill; owns the EOM latch.
// Assumes DATA_W is a power of two and CRC_W > DATA_W.
module stx_shifter
    import stx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 16,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              auto_cts,
    input  logic              cts_n,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              crc_en,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_q,
    input  logic [DATA_W-1:0] sync_q,
    input  logic              crc_inv,
    input  logic [CRC_W-1:0]  crc_next,
    input  logic              cmd_reset_eom,
    input  logic              auto_eom,
    input  logic              data_wr,
    output logic              txd,
    output logic              take,
    output logic              crc_step,
    output logic              crc_bit,
    output logic              eom,
    output logic              ext_irq,
    output tx_state_e         tx_state
);
    localparam int CNT_W   = $clog2(CRC_W);
    localparam int SI_W    = $clog2(DATA_W);
    localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;
    localparam int PAD_W   = CRC_W - DATA_W;

    logic [CRC_W-1:0]  sh;
    logic [CNT_W-1:0]  cnt, last, char_len, pad;
    logic [DATA_W-1:0] aligned;
    logic [SI_W-1:0]   sync_idx;
    logic              crc_flag, abort, en_eff, at_end, start_crc;

    // Derived character geometry and boundary decisions.
    always_comb begin
        en_eff   = tx_en && (!auto_cts || !cts_n);
        char_len = CNT_W'(MIN_LEN) + CNT_W'(len_code);
        pad      = CNT_W'(DATA_W) - char_len;
        aligned  = buf_q << pad;
        case (tx_state)
            ST_DATA: last = char_len - 1'b1;
            ST_CRC:  last = CNT_W'(CRC_W - 1);
            default: last = CNT_W'(DATA_W - 1);
        endcase
        at_end    = (tx_state == ST_OFF) || (cnt == last);
        take      = at_end && en_eff && buf_full;
        start_crc = at_end && en_eff && !buf_full && !eom;
        crc_step  = (tx_state == ST_DATA) && crc_flag;
        crc_bit   = sh[CRC_W-1];
        sync_idx  = SI_W'(DATA_W - 1) - cnt[SI_W-1:0];
    end

    // Serial output: idle high when off, sync bits once a CRC was aborted.
    always_comb begin
        if (tx_state == ST_OFF) txd = 1'b1;
        else if (abort)         txd = sync_q[sync_idx];
        else                    txd = sh[CRC_W-1];
    end

    // Phase, shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_state <= ST_OFF;
            sh       <= '0;
            cnt      <= '0;
            crc_flag <= 1'b0;
            abort    <= 1'b0;
        end else if (at_end) begin
            cnt   <= '0;
            abort <= 1'b0;
            if (!en_eff) begin
                tx_state <= ST_OFF;
            end else if (buf_full) begin
                tx_state <= ST_DATA;
                sh       <= {aligned, {PAD_W{1'b0}}};
                crc_flag <= crc_en;
            end else if (!eom) begin
                tx_state <= ST_CRC;
                sh       <= crc_inv ? ~crc_next : crc_next;
            end else begin
                tx_state <= ST_SYNC;
                sh       <= {sync_q, {PAD_W{1'b0}}};
            end
        end else begin
            sh  <= sh << 1;
            cnt <= cnt + 1'b1;
            if (tx_state == ST_CRC && !en_eff) abort <= 1'b1;
        end
    end

    // End-of-message latch: hardware sets it, host command or auto-clear resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  eom <= 1'b1;
        else if (start_crc)                          eom <= 1'b1;
        else if (cmd_reset_eom || (auto_eom && data_wr)) eom <= 1'b0;
    end

    // One-cycle status interrupt on the latch set.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_irq <= 1'b0;
        else        ext_irq <= start_crc;
    end
endmodule

// File: rtl/sync_tx_crc.sv
// Top level of the synchronous transmitter with CRC trailer.
// Joins host registers, CRC generator and output sequencer.
module sync_tx_crc
    import stx_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter int               CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_reset_eom,
    input  logic              cmd_reset_crc,
    input  logic              cts_n,
    output logic              txd,
    output logic              rts_n,
    output logic              cts_status,
    output logic              buf_empty,
    output logic              eom,
    output logic              ext_irq
);
    localparam int LEN_W = 2;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] sync_q, buf_q;
    logic [CRC_W-1:0]  crc_next;
    logic              crc_inv_q, buf_full, data_wr, take, crc_step, crc_bit;
    logic              auto_eom_w;
    tx_state_e         tx_state;

    assign rts_n      = ~ctrl_q.rts;
    assign buf_empty  = ~buf_full;
    assign auto_eom_w = ctrl_q.auto_eom;

    stx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .take, .cts_n,
        .ctrl_q, .sync_q, .crc_inv_q, .buf_q, .buf_full,
        .cts_seen(cts_status), .data_wr
    );

    stx_crc #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
        .clk, .rst_n, .clr(cmd_reset_crc), .preset_ones(ctrl_q.preset_ones),
        .step(crc_step), .bit_in(crc_bit), .crc_next
    );

    stx_shifter #(.DATA_W(DATA_W), .CRC_W(CRC_W), .LEN_W(LEN_W)) u_shift (
        .clk, .rst_n, .tx_en(ctrl_q.tx_en), .auto_cts(ctrl_q.auto_cts), .cts_n,
        .len_code(ctrl_q.len_code), .crc_en(ctrl_q.crc_en), .buf_full, .buf_q,
        .sync_q, .crc_inv(crc_inv_q), .crc_next, .cmd_reset_eom,
        .auto_eom(auto_eom_w), .data_wr, .txd, .take, .crc_step, .crc_bit,
        .eom, .ext_irq, .tx_state
    );
endmodule

// File: rtl/stx_checker.sv
// Protocol checks on the transmitter ports, attached by bind.
module stx_checker
    import stx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       cmd_reset_eom,
    input logic       cts_n,
    input logic       txd,
    input logic       rts_n,
    input logic       cts_status,
    input logic       eom,
    input logic       ext_irq,
    input logic       auto_eom,
    input tx_state_e  tx_state
);
    p_irq_with_eom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> eom);

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |=> !ext_irq);

    p_eom_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eom && !cmd_reset_eom && !(wr_en && wr_addr == A_DATA && auto_eom)) |=> eom);

    p_off_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state == ST_OFF) |-> txd);

    p_rts_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL) |=> (rts_n == !$past(wr_data[1])));

    p_cts_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cts_status == !$past(cts_n)));
endmodule

bind sync_tx_crc stx_checker u_chk (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .cmd_reset_eom, .cts_n,
    .txd, .rts_n, .cts_status, .eom, .ext_irq,
    .auto_eom(auto_eom_w), .tx_state(tx_state)
);

// File: tb/sync_tx_crc_test.sv
`timescale 1ns/1ps
module sync_tx_crc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       cmd_reset_eom = 1'b0, cmd_reset_crc = 1'b0, cts_n = 1'b0;
    logic       txd, rts_n, cts_status, buf_empty, eom, ext_irq;

    always #2.5 clk = ~clk;

    sync_tx_crc uut (.*);

    int   nvec = 0, nfail = 0, irqs = 0, ep = 0, nxt = 0, nmsg = 0;
    logic exp_b [0:255];
    logic got_b [0:255];
    logic [7:0]  msg [0:3];
    logic [7:0]  ctl = 8'd0;
    logic [15:0] mcrc;

    task automatic check(input string tag, input int act, input int expv);
        nvec++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic b);
        exp_b[ep] = b;
        ep++;
    endtask

    task automatic push_char(input logic [15:0] v, input int len, input logic crc_on);
        for (int k = len - 1; k >= 0; k--) begin
            push(v[k]);
            if (crc_on) mcrc = {mcrc[14:0], 1'b0} ^ ((mcrc[15] ^ v[k]) ? 16'h1021 : 16'h0);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit which_eom);
        if (which_eom) cmd_reset_eom = 1'b1; else cmd_reset_crc = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_reset_eom = 1'b0; cmd_reset_crc = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    // Drives the enable write, then records n bits; optional disable at dis_at.
    task automatic run_stream(input int n, input int dis_at);
        irqs = 0;
        ctl[0] = 1'b1; wr_addr = 2'd1; wr_data = ctl; wr_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            wr_en = 1'b0;
            got_b[i] = txd;
            if (ext_irq) irqs++;
            if (i == dis_at) begin
                ctl[0] = 1'b0; wr_addr = 2'd1; wr_data = ctl; wr_en = 1'b1;
            end else if (nxt < nmsg && buf_empty) begin
                wr_addr = 2'd0; wr_data = msg[nxt]; wr_en = 1'b1; nxt++;
            end
        end
        if (wr_en) begin @(posedge clk); @(negedge clk); wr_en = 1'b0; end
    endtask

    task automatic cmp(input int n, input int a_end, input int b_end,
                       input string ta, input string tb, input string tc);
        for (int i = 0; i < n; i++) begin
            string t;
            t = (i < a_end) ? ta : ((i < b_end) ? tb : tc);
            check($sformatf("%s bit %0d", t, i), int'(got_b[i]), int'(exp_b[i]));
        end
    endtask

    task automatic stop_tx();
        ctl[0] = 1'b0;
        host_wr(2'd1, ctl);
        idle(20);
        check("R7 line idle after stop", int'(txd), 1);
    endtask

    // Loads configuration and the first byte while the transmitter is off.
    task automatic setup(input int code, input bit crcen, input bit inv, input bit pre,
                         input bit aut, input logic [7:0] sy, input int nbytes);
        ctl = {pre, aut, 1'b0, code[1:0], crcen, 1'b0, 1'b0};
        host_wr(2'd1, ctl);
        host_wr(2'd3, {7'd0, inv});
        host_wr(2'd2, sy);
        pulse(1'b0);
        host_wr(2'd0, msg[0]);
        if (!aut) pulse(1'b1);
        check(aut ? "R6 eom cleared by data write" : "R5 eom cleared by command",
              int'(eom), 0);
        nmsg = nbytes; nxt = 1;
        ep = 0;
        mcrc = pre ? 16'hFFFF : 16'h0000;
        push(1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 txd", int'(txd), 1);
        check("R1 rts_n", int'(rts_n), 1);
        check("R1 buf_empty", int'(buf_empty), 1);
        check("R1 eom", int'(eom), 1);
        check("R1 ext_irq", int'(ext_irq), 0);

        // R9 request-to-send follows control bit 1 inverted
        ctl = 8'h02; host_wr(2'd1, ctl);
        check("R9 rts asserted", int'(rts_n), 0);
        ctl = 8'h00; host_wr(2'd1, ctl);
        check("R9 rts released", int'(rts_n), 1);

        // R3 idle sync fill with empty buffer and eom set
        host_wr(2'd2, 8'hA7);
        nmsg = 0; nxt = 0; ep = 0;
        push(1'b1);
        for (int k = 0; k < 3; k++) push_char(16'hA7, 8, 1'b0);
        run_stream(ep, -1);
        cmp(ep, 0, 0, "R3", "R3", "R3");
        check("R3 no interrupt in fill", irqs, 0);
        stop_tx();

        // R2 R4 R5 sweep over length, inversion, preset and auto-clear
        for (int cfg = 0; cfg < 16; cfg++) begin
            int L, code, aend;
            bit inv, pre, aut;
            logic [7:0] sy;
            code = cfg & 3; L = 5 + code;
            inv = cfg[2]; pre = cfg[3]; aut = cfg[0] ^ cfg[2];
            sy = 8'((8'h96 + cfg * 13) & 8'hFF);
            for (int k = 0; k < 3; k++) msg[k] = 8'((cfg * 29 + k * 71 + 3) & 8'hFF);
            setup(code, 1'b1, inv, pre, aut, sy, 3);
            for (int k = 0; k < 3; k++) push_char({8'd0, msg[k] & 8'((1 << L) - 1)}, L, 1'b1);
            aend = ep;
            push_char(inv ? ~mcrc : mcrc, 16, 1'b0);
            push_char({8'd0, sy}, 8, 1'b0);
            push_char({8'd0, sy}, 8, 1'b0);
            run_stream(ep, -1);
            cmp(ep, aend, aend + 16, "R2", "R4", "R3");
            check("R5 single interrupt", irqs, 1);
            check("R5 eom set after trailer", int'(eom), 1);
            stop_tx();
        end

        // R4 characters loaded with CRC-enable clear leave the preset untouched
        msg[0] = 8'h5C; msg[1] = 8'hE1;
        setup(3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h33, 2);
        push_char(16'h5C, 8, 1'b0);
        push_char(16'hE1, 8, 1'b0);
        push_char(mcrc, 16, 1'b0);
        push_char(16'h33, 8, 1'b0);
        run_stream(ep, -1);
        cmp(ep, 17, 33, "R2", "R4 excluded", "R3");
        stop_tx();

        // R7 disable in the middle of the second character
        msg[0] = 8'h2B; msg[1] = 8'h15; msg[2] = 8'h3F;
        setup(1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7E, 3);
        push_char(16'h2B, 6, 1'b1);
        push_char(16'h15, 6, 1'b1);
        for (int k = 0; k < 10; k++) push(1'b1);
        run_stream(ep, 9);
        cmp(ep, 13, 13, "R7", "R7", "R7 idle");
        check("R7 buffered byte kept", int'(buf_empty), 0);
        check("R7 no trailer started", int'(eom), 0);
        stop_tx();

        // R8 disable during the trailer: rest of 16 bits from sync register
        msg[0] = 8'hC4; msg[1] = 8'h39;
        setup(3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 2);
        push_char(16'hC4, 8, 1'b1);
        push_char(16'h39, 8, 1'b1);
        for (int j = 0; j < 16; j++) begin
            if (j < 6) push(mcrc[15 - j]);
            else       push(1'(8'h5A >> (7 - (j % 8))));
        end
        for (int k = 0; k < 8; k++) push(1'b1);
        run_stream(ep, 21);
        cmp(ep, 17, 33, "R2", "R8", "R8 idle");
        check("R8 eom set", int'(eom), 1);
        stop_tx();

        // R10 clear-to-send gating and status
        cts_n = 1'b1;
        idle(1);
        check("R10 status low", int'(cts_status), 0);
        msg[0] = 8'h81;
        ctl = 8'h38; host_wr(2'd1, ctl);
        host_wr(2'd0, 8'h81);
        ctl[0] = 1'b1; host_wr(2'd1, ctl);
        begin
            int highs;
            highs = 0;
            for (int k = 0; k < 30; k++) begin
                idle(1);
                if (txd) highs++;
            end
            check("R10 held off by cts", highs, 30);
        end
        check("R10 buffer not taken", int'(buf_empty), 0);
        cts_n = 1'b0;
        idle(3);
        check("R10 runs once cts low", int'(buf_empty), 1);
        check("R10 status high", int'(cts_status), 1);
        stop_tx();
        cts_n = 1'b1;
        ctl = 8'h19; host_wr(2'd1, ctl);
        host_wr(2'd0, 8'h42);
        idle(12);
        check("R10 cts ignored without auto", int'(buf_empty), 1);
        stop_tx();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule